// File: doc/BRIEF.md
# Two-Stage I2C Clock Timebase

This block turns a fast system clock into the bit timing of an I2C controller. It has two cascaded programmable prescalers. The first stage divides the clock by (A+1). The second stage counts (B+1) first-stage ticks to make one base tick. A 22-step phase counter then splits each SCL period into base ticks. The SCL line is pulled low for the first 11 base ticks and released for the last 11. The resulting SCL rate is f_clk / (22·(A+1)·(B+1)). The largest combined prescale is 256, and the firmware that programs the divisors keeps the resulting rate at or below 400 kHz.

The bit engine consumes three single-cycle strobes: the release of SCL, the start of its low phase, and the point inside the low phase where SDA may change. The sampled SCL line comes back in as an input. When a target holds the clock low during the release half, all counting freezes until the line is seen high.

The divisors come from a control word. They are copied into internal holding registers while the block is idle and again at each period boundary. A change written during a transfer therefore never produces a truncated or stretched half period.

Top module: `i2c_scl_timebase`

## Requirements
- R1: While reset is asserted, and after it is released with `enable` low, `scl_low`, `rise_stb`, `fall_stb` and `sda_stb` are all 0.
- R2: Divisor A is taken from `ctrl_word[15:14]` (0..3) and divisor B from `ctrl_word[13:8]` (0..63). Bits [7:0] have no effect on any output.
- R3: Let u = (A+1)(B+1) and count cycles from the first cycle with `enable` high, with no stretching. The period is 22·u cycles. `scl_low` is 1 in cycles 0 .. 11u-1 of each period and 0 in cycles 11u .. 22u-1.
- R4: `rise_stb` is 1 for exactly one cycle, cycle 11u-1 of each period. `fall_stb` is 1 for exactly one cycle, cycle 22u-1 of each period. No two strobes are ever high together.
- R5: `sda_stb` is 1 for exactly one cycle, cycle 5u-1 of each period, which lies inside the low half.
- R6: In the release half, while `scl_sense` is 0, the position within the period does not advance, no strobe is raised, and `scl_low` stays 0. Counting resumes from the same position once `scl_sense` is 1.
- R7: A new divisor value written while `enable` is high is used only from the period that follows the next `fall_stb`. The period in progress keeps the old timing.
- R8: With `enable` low, all outputs are 0 and the position is cleared. The next rise of `enable` starts a fresh period with SCL low, using the divisors present in the control word before the cycle in which `enable` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| enable | input | 1 | Runs the timebase; low clears the position |
| ctrl_word | input | 16 | Control word holding divisor A [15:14] and divisor B [13:8] |
| scl_sense | input | 1 | Sampled level of the SCL wire |
| scl_low | output | 1 | 1 = pull SCL low, 0 = release it |
| rise_stb | output | 1 | One-cycle strobe on the last cycle of the low half |
| fall_stb | output | 1 | One-cycle strobe on the last cycle of the period |
| sda_stb | output | 1 | One-cycle strobe at the SDA change point in the low half |

## Verification
Three corner cases get the most attention: the extreme divisors (both zero, giving a 22-cycle period, and both maximum, giving a 5632-cycle period), divisor writes landing in the middle of a period, and stretching that starts or ends at arbitrary points in the release half. If a design loaded new divisors immediately, one half period would come out at the wrong length. If it let the first stage keep running during a stretch, the strobes after the release would come early by a fraction of a base tick. If it swapped the two fields or decoded the low byte, periods would stop matching 22·(A+1)·(B+1) under random control words. The bench also disables the block in the middle of a period, to catch a design that resumes from a stale position instead of starting a new low half.

// File: rtl/i2c_scl_timebase_pkg.sv
package i2c_scl_timebase_pkg;
  localparam int unsigned PHASES    = 22;
  localparam int unsigned HALF      = PHASES / 2;
  localparam int unsigned SDA_POINT = 5;
  localparam int unsigned PH_W      = $clog2(PHASES);
  typedef logic [PH_W-1:0] phase_t;
endpackage

// File: rtl/sclt_stage.sv
module sclt_stage #(
  parameter int unsigned W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         adv,
  input  logic [W-1:0] limit,
  output logic         tick
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = adv && (cnt_q == limit);
    cnt_d = cnt_q;
    if (clr)       cnt_d = '0;
    else if (tick) cnt_d = '0;
    else if (adv)  cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/sclt_phase.sv
module sclt_phase
  import i2c_scl_timebase_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   enable,
  input  logic   step,
  output phase_t ph,
  output logic   hi_half,
  output logic   scl_low,
  output logic   rise_stb,
  output logic   fall_stb,
  output logic   sda_stb
);
  phase_t ph_q, ph_d;
  logic   at_end;

  always_comb begin
    at_end   = (ph_q == phase_t'(PHASES - 1));
    hi_half  = (ph_q >= phase_t'(HALF));
    scl_low  = enable && !hi_half;
    rise_stb = step && (ph_q == phase_t'(HALF - 1));
    fall_stb = step && at_end;
    sda_stb  = step && (ph_q == phase_t'(SDA_POINT - 1));
    ph_d     = ph_q;
    if (!enable)     ph_d = '0;
    else if (step)   ph_d = at_end ? '0 : ph_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= '0;
    else        ph_q <= ph_d;
  end

  assign ph = ph_q;
endmodule

// File: rtl/i2c_scl_timebase.sv
module i2c_scl_timebase
  import i2c_scl_timebase_pkg::*;
#(
  parameter int unsigned CTRL_W = 16,
  parameter int unsigned A_W    = 2,
  parameter int unsigned B_W    = 6,
  parameter int unsigned B_LSB  = 8,
  localparam int unsigned A_LSB = B_LSB + B_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [CTRL_W-1:0] ctrl_word,
  input  logic              scl_sense,
  output logic              scl_low,
  output logic              rise_stb,
  output logic              fall_stb,
  output logic              sda_stb
);
  // reset: asserted asynchronously, released through two flops
  logic rst_meta_n, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  logic unused_ctrl_bits;
  assign unused_ctrl_bits = ^ctrl_word[B_LSB-1:0];

  // divisor holding registers, reloaded while idle or at period end
  logic [A_W-1:0] lat_a_q, lat_a_d;
  logic [B_W-1:0] lat_b_q, lat_b_d;
  logic           period_end;

  always_comb begin
    lat_a_d = lat_a_q;
    lat_b_d = lat_b_q;
    if (!enable || period_end) begin
      lat_a_d = ctrl_word[A_LSB +: A_W];
      lat_b_d = ctrl_word[B_LSB +: B_W];
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      lat_a_q <= '0;
      lat_b_q <= '0;
    end else begin
      lat_a_q <= lat_a_d;
      lat_b_q <= lat_b_d;
    end
  end

  // stall: released half with the line still seen low
  logic   hi_half, stall, run, a_tick, base_tick;
  phase_t phase_idx;

  assign stall = enable && hi_half && !scl_sense;
  assign run   = enable && !stall;

  sclt_stage #(.W(A_W)) u_stage_a (
    .clk(clk), .rst_n(rst_sync_n), .clr(!enable), .adv(run),
    .limit(lat_a_q), .tick(a_tick)
  );

  sclt_stage #(.W(B_W)) u_stage_b (
    .clk(clk), .rst_n(rst_sync_n), .clr(!enable), .adv(a_tick),
    .limit(lat_b_q), .tick(base_tick)
  );

  sclt_phase u_phase (
    .clk(clk), .rst_n(rst_sync_n), .enable(enable), .step(base_tick),
    .ph(phase_idx), .hi_half(hi_half), .scl_low(scl_low),
    .rise_stb(rise_stb), .fall_stb(fall_stb), .sda_stb(sda_stb)
  );

  assign period_end = fall_stb;
endmodule

// File: rtl/i2c_scl_timebase_chk.sv
module i2c_scl_timebase_chk
  import i2c_scl_timebase_pkg::*;
#(
  parameter int unsigned A_W = 2,
  parameter int unsigned B_W = 6
) (
  input logic           clk,
  input logic           rst_n,
  input logic           enable,
  input logic           scl_sense,
  input logic           scl_low,
  input logic           rise_stb,
  input logic           fall_stb,
  input logic           sda_stb,
  input logic           hi_half,
  input phase_t         phase_idx,
  input logic [A_W-1:0] lat_a_q,
  input logic [B_W-1:0] lat_b_q
);
  // R4: strobes never overlap
  a_r4_strobe_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rise_stb, fall_stb, sda_stb}));

  // R6: no strobe while the line is held low in the release half
  a_r6_stall_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && hi_half && !scl_sense) |-> !(rise_stb || fall_stb || sda_stb));

  // R6: position frozen across a stalled cycle
  a_r6_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && hi_half && !scl_sense) ##1 enable |-> $stable(phase_idx));

  // R8: idle means nothing driven
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> !(scl_low || rise_stb || fall_stb || sda_stb));

  // R3: every run starts with SCL pulled low
  a_r3_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(enable) |-> scl_low);

  // R7: divisors held except at a period boundary
  a_r7_div_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !fall_stb) |=> $stable({lat_a_q, lat_b_q}));
endmodule

bind i2c_scl_timebase i2c_scl_timebase_chk #(.A_W(A_W), .B_W(B_W)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .enable(enable), .scl_sense(scl_sense),
  .scl_low(scl_low), .rise_stb(rise_stb), .fall_stb(fall_stb),
  .sda_stb(sda_stb), .hi_half(hi_half), .phase_idx(phase_idx),
  .lat_a_q(lat_a_q), .lat_b_q(lat_b_q)
);

// File: tb/tb_i2c_scl_timebase.sv
`timescale 1ns/1ps
module tb_i2c_scl_timebase;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        enable;
  logic [15:0] ctrl_word;
  logic        stretch;
  logic        scl_sense;
  logic        scl_low, rise_stb, fall_stb, sda_stb;

  always #2.5 clk = ~clk;

  assign scl_sense = !scl_low && !stretch;

  i2c_scl_timebase dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .ctrl_word(ctrl_word),
    .scl_sense(scl_sense), .scl_low(scl_low), .rise_stb(rise_stb),
    .fall_stb(fall_stb), .sda_stb(sda_stb)
  );

  int    checks = 0;
  int    errors = 0;
  bit    done   = 1'b0;
  string ctx    = "";

  // requirement-level model state
  int m_a = 0, m_b = 0, tm = 0;

  function automatic int unit_of(int a, int b);
    return (a + 1) * (b + 1);
  endfunction

  task automatic cmp(input bit act, input bit exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s [%s] actual %0b expected %0b", tag, ctx, act, exp);
    end
  endtask

  task automatic cycle(input bit en, input logic [15:0] c, input bit st);
    int u, ph;
    bit stall;
    @(posedge clk);
    #1;
    enable = en; ctrl_word = c; stretch = st;
    #0.5;
    u     = unit_of(m_a, m_b);
    ph    = tm / u;
    stall = en && (ph >= 11) && st;
    cmp(scl_low,  en && (ph < 11),                     "R3 scl_low");
    cmp(rise_stb, en && !stall && (tm == 11 * u - 1),  "R4 rise_stb");
    cmp(fall_stb, en && !stall && (tm == 22 * u - 1),  "R4 fall_stb");
    cmp(sda_stb,  en && !stall && (tm == 5 * u - 1),   "R5 sda_stb");
    if (!en) begin
      m_a = int'(c[15:14]); m_b = int'(c[13:8]); tm = 0;
    end else if (!stall) begin
      if (tm == 22 * u - 1) begin
        tm = 0; m_a = int'(c[15:14]); m_b = int'(c[13:8]);
      end else tm++;
    end
  endtask

  function automatic logic [15:0] mk(int a, int b, int low);
    return {2'(a), 6'(b), 8'(low)};
  endfunction

  initial begin
    #(5.0 * 190000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired [%s]", ctx);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] c;
    bit st;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; enable = 1'b0; ctrl_word = '0; stretch = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    ctx = "R1 in reset";
    cmp(scl_low,  1'b0, "R1 scl_low");
    cmp(rise_stb, 1'b0, "R1 rise_stb");
    cmp(fall_stb, 1'b0, "R1 fall_stb");
    cmp(sda_stb,  1'b0, "R1 sda_stb");
    rst_n = 1'b1;
    ctx = "R1 after release";
    for (int i = 0; i < 6; i++) cycle(1'b0, 16'h0000, 1'b0);

    // R3: smallest divisors, 22-cycle period
    ctx = "R3 min divisors";
    c = mk(0, 0, 0);
    cycle(1'b0, c, 1'b0);
    for (int i = 0; i < 66; i++) cycle(1'b1, c, 1'b0);
    cycle(1'b0, c, 1'b0);

    // R3: largest divisors, 5632-cycle period
    ctx = "R3 max divisors";
    c = mk(3, 63, 0);
    cycle(1'b0, c, 1'b0);
    for (int i = 0; i < 5632 + 40; i++) cycle(1'b1, c, 1'b0);
    cycle(1'b0, c, 1'b0);

    // R2: low byte filled with ones must not matter
    ctx = "R2 low byte ignored";
    c = mk(1, 2, 8'hFF);
    cycle(1'b0, c, 1'b0);
    for (int i = 0; i < 300; i++) cycle(1'b1, c, 1'b0);

    // R7: divisor write mid-period
    ctx = "R7 change mid period";
    c = mk(0, 2, 8'h00);
    for (int i = 0; i < 200; i++) cycle(1'b1, c, 1'b0);

    // R6: long stretch through the release half
    ctx = "R6 stretch";
    c = mk(1, 1, 8'h00);
    cycle(1'b0, c, 1'b0);
    for (int i = 0; i < 400; i++) cycle(1'b1, c, (i % 97) > 50);

    // R8: drop enable mid-period, then restart with new divisors
    ctx = "R8 disable mid period";
    for (int i = 0; i < 10; i++) cycle(1'b0, mk(2, 3, 0), 1'b0);
    for (int i = 0; i < 400; i++) cycle(1'b1, mk(2, 3, 0), 1'b0);

    // R2 R6 R7 R8: random segments
    ctx = "R2 random fields";
    for (int seg = 0; seg < 25; seg++) begin
      int len;
      int b;
      b   = (seg % 3 == 0) ? int'($urandom % 64) : int'($urandom % 8);
      c   = mk(int'($urandom % 4), b, int'($urandom % 256));
      len = 200 + int'($urandom % 2000);
      st  = 1'b0;
      cycle(1'b0, c, 1'b0);
      for (int i = 0; i < len; i++) begin
        bit en;
        if ($urandom % 300 == 0) c = mk(int'($urandom % 4), int'($urandom % 8), int'($urandom % 256));
        if ($urandom % 20 == 0) st = !st;
        en = ($urandom % 1000) != 0;
        cycle(en, c, st);
      end
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule